// File: doc/BRIEF.md
# Inverted Page Table Translation Unit

This block turns a (process ID, virtual page, offset) request into a physical address. It uses an inverted table that holds one entry per physical frame. The frame number is never stored in an entry. It is the entry's position in the table. A fold of the process ID XOR the page number picks the table slot. The slot address sent to memory is the table base plus that slot number.

The block makes exactly one memory read per request. It then compares the owner tags in the returned entry with the request. It answers with a hit, or with a page fault or a protection fault. On a hit, the physical address is the slot number with the untouched offset appended below it.

Requests and responses use valid/ready handshakes. The block serves one lookup at a time. The read port returns data through a valid strobe after any latency.

The FSM has four states:
- **S_IDLE** accepts a request when `req_valid` is high, moving to S_ISSUE.
- **S_ISSUE** pulses the memory read for one cycle, then moves to S_WAIT.
- **S_WAIT** holds until `mem_rd_valid`, evaluates the entry and moves to S_RESP.
- **S_RESP** presents the answer until `rsp_ready`, then returns to S_IDLE.

Top module: `ipt_lookup`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: The read address equals `tbl_base` plus the slot number, modulo 2^16. The slot number is k[4:0] XOR k[9:5], where k is the 10-bit zero-extended pid XOR vpn.
- R3: The response is a hit exactly in this case: the entry's resident bit (bit 0) is set, its pid field (bits 17:10) and vpn field (bits 9:4) equal the request, and the access is allowed. A hit carries fault code 0 and `rsp_paddr` = {slot, offset}.
- R4: If either the stored pid or the stored vpn differs from the request, the response is a page fault. A page fault has hit 0, fault code 1 and `rsp_paddr` 0.
- R5: An entry with the resident bit clear gives a page fault (code 1), even when its tags match. This also holds for a write to an entry without write permission.
- R6: A write is a protection fault (code 2, hit 0, paddr 0) in this case: the entry is resident, its tags match, and its write-permit bit (bit 1) is clear. A read of the same entry hits. The dirty bit (bit 2) and used bit (bit 3) do not affect the result.
- R7: Each lookup makes exactly one single-cycle read pulse. `req_ready` stays 0 from acceptance until the response is taken.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, the response stays valid and its hit, fault and address hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tbl_base | input | 16 | Table base address, sampled with the request |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can accept a request |
| req_pid | input | 8 | Requesting process ID |
| req_vpn | input | 6 | Virtual page number |
| req_off | input | 10 | Page offset |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| rsp_paddr | output | 15 | Physical address {frame, offset} |
| mem_rd_en | output | 1 | Table read strobe |
| mem_rd_addr | output | 16 | Table entry address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 18 | Table entry contents |

## Verification
The bench covers every page number over a spread of process IDs, so the fold of the upper key bits is exercised. A hash that dropped the upper bits, or that never added the base, would read from the wrong address.

It applies seven entry patterns. The mismatch patterns flip a single pid or vpn bit, so a design that compared only one tag would report a false hit. The pattern that is non-resident and write-protected catches a design that checks protection ahead of residency, because it would return code 2 instead of 1.

Read latency varies, and some responses are held back to confirm the outputs stay stable. A design that re-issued the read, or dropped the answer under backpressure, would fail the count or the hold checks.

// File: rtl/ipt_pkg.sv
package ipt_pkg;
    parameter int PID_W = 8;
    parameter int VPN_W = 6;
    parameter int OFF_W = 10;
    parameter int IDX_W = 5;

    localparam int KEY_W  = (PID_W > VPN_W) ? PID_W : VPN_W;
    localparam int FOLD_N = (KEY_W + IDX_W - 1) / IDX_W;
    localparam int FOLD_W = FOLD_N * IDX_W;
    localparam int PA_W   = IDX_W + OFF_W;

    typedef struct packed {
        logic [PID_W-1:0] pid;
        logic [VPN_W-1:0] vpn;
        logic             used;
        logic             dirty;
        logic             wr_ok;
        logic             resident;
    } ipt_entry_t;

    localparam int ENT_W = $bits(ipt_entry_t);

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_PAGE = 2'd1,
        FLT_PROT = 2'd2
    } fault_e;
endpackage

// File: rtl/ipt_hash.sv
module ipt_hash
    import ipt_pkg::*;
(
    input  logic [PID_W-1:0] pid,
    input  logic [VPN_W-1:0] vpn,
    output logic [IDX_W-1:0] idx
);
    logic [FOLD_W-1:0] key;

    assign key = FOLD_W'(pid) ^ FOLD_W'(vpn);

    // fold the key into IDX_W bits chunk by chunk
    always_comb begin
        idx = '0;
        for (int g = 0; g < FOLD_N; g++) begin
            idx = idx ^ key[g*IDX_W +: IDX_W];
        end
    end
endmodule

// File: rtl/ipt_match.sv
module ipt_match
    import ipt_pkg::*;
(
    input  ipt_entry_t       ent,
    input  logic [PID_W-1:0] pid,
    input  logic [VPN_W-1:0] vpn,
    input  logic             is_wr,
    output logic             hit,
    output fault_e           fault
);
    logic tag_eq;

    assign tag_eq = (ent.pid == pid) && (ent.vpn == vpn);

    // residency and ownership outrank protection
    always_comb begin
        hit   = 1'b0;
        fault = FLT_PAGE;
        if (ent.resident && tag_eq) begin
            if (is_wr && !ent.wr_ok) begin
                fault = FLT_PROT;
            end else begin
                hit   = 1'b1;
                fault = FLT_NONE;
            end
        end
    end
endmodule

// File: rtl/ipt_lookup.sv
module ipt_lookup
    import ipt_pkg::*;
#(
    parameter int MADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MADDR_W-1:0] tbl_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PID_W-1:0]   req_pid,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [OFF_W-1:0]   req_off,
    input  logic               req_write,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic               rsp_hit,
    output logic [1:0]         rsp_fault,
    output logic [PA_W-1:0]    rsp_paddr,
    output logic               mem_rd_en,
    output logic [MADDR_W-1:0] mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [ENT_W-1:0]   mem_rd_data
);
    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;

    state_e state, nxt;

    logic [PID_W-1:0]   pid_q;
    logic [VPN_W-1:0]   vpn_q;
    logic [OFF_W-1:0]   off_q;
    logic               wr_q;
    logic [IDX_W-1:0]   idx_q;
    logic [MADDR_W-1:0] base_q;
    logic               hit_q;
    fault_e             flt_q;

    logic [IDX_W-1:0]   idx_d;
    logic               m_hit;
    fault_e             m_flt;

    ipt_hash u_hash (
        .pid (req_pid),
        .vpn (req_vpn),
        .idx (idx_d)
    );

    ipt_match u_match (
        .ent   (ipt_entry_t'(mem_rd_data)),
        .pid   (pid_q),
        .vpn   (vpn_q),
        .is_wr (wr_q),
        .hit   (m_hit),
        .fault (m_flt)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (req_valid)    nxt = S_ISSUE;
            S_ISSUE:                   nxt = S_WAIT;
            S_WAIT:  if (mem_rd_valid) nxt = S_RESP;
            S_RESP:  if (rsp_ready)    nxt = S_IDLE;
            default:                   nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pid_q  <= '0;
            vpn_q  <= '0;
            off_q  <= '0;
            wr_q   <= 1'b0;
            idx_q  <= '0;
            base_q <= '0;
            hit_q  <= 1'b0;
            flt_q  <= FLT_NONE;
        end else if (state == S_IDLE && req_valid) begin
            pid_q  <= req_pid;
            vpn_q  <= req_vpn;
            off_q  <= req_off;
            wr_q   <= req_write;
            idx_q  <= idx_d;
            base_q <= tbl_base;
        end else if (state == S_WAIT && mem_rd_valid) begin
            hit_q  <= m_hit;
            flt_q  <= m_flt;
        end
    end

    always_comb begin
        req_ready   = (state == S_IDLE);
        mem_rd_en   = (state == S_ISSUE);
        rsp_valid   = (state == S_RESP);
        mem_rd_addr = base_q + MADDR_W'(idx_q);
        rsp_hit     = hit_q;
        rsp_fault   = flt_q;
        rsp_paddr   = hit_q ? {idx_q, off_q} : '0;
    end
endmodule

// File: rtl/ipt_chk.sv
module ipt_chk
    import ipt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic            rsp_hit,
    input logic [1:0]      rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            mem_rd_en
);
    // R7
    single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R7
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || rsp_valid) |-> !req_ready);

    // R8
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit)
                                       && $stable(rsp_fault) && $stable(rsp_paddr)));

    // R3
    hit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (rsp_fault == 2'd0));

    // R4
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_fault != 2'd0 && rsp_paddr == '0));
endmodule

bind ipt_lookup ipt_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr),
    .mem_rd_en (mem_rd_en)
);

// File: tb/tb_ipt_lookup.sv
module tb_ipt_lookup;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tbl_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_pid = '0;
    logic [5:0]  req_vpn = '0;
    logic [9:0]  req_off = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_hit;
    logic [1:0]  rsp_fault;
    logic [14:0] rsp_paddr;
    logic        mem_rd_en;
    logic [15:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [17:0] mem_rd_data = '0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    ipt_lookup dut (
        .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_pid(req_pid), .req_vpn(req_vpn), .req_off(req_off),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    // memory model state
    int          lat = 0;
    int          m_cnt = 0;
    bit          m_pend = 1'b0;
    logic [15:0] m_addr = '0;
    int          rd_count = 0;
    logic [17:0] cur_entry = '0;

    always @(posedge clk) begin
        mem_rd_valid <= 1'b0;
        if (mem_rd_en) begin
            rd_count <= rd_count + 1;
            m_addr   <= mem_rd_addr;
            m_pend   <= 1'b1;
            m_cnt    <= lat;
        end else if (m_pend) begin
            if (m_cnt == 0) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= cur_entry;
                m_pend       <= 1'b0;
            end else begin
                m_cnt <= m_cnt - 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] slot_of(input logic [7:0] p, input logic [5:0] v);
        int x;
        x = int'(p) ^ int'(v);
        return 5'((x % 32) ^ (x / 32));
    endfunction

    task automatic lookup(input int mode, input logic [7:0] p, input logic [5:0] v,
                          input logic [9:0] off, input logic [15:0] base,
                          input bit hold, input int n);
        logic [7:0]  ep;
        logic [5:0]  ev;
        bit          res;
        bit          wok;
        bit          wr;
        bit          exp_hit;
        int          exp_flt;
        logic [4:0]  h;
        logic [14:0] exp_pa;
        int          rd0;
        int          cnt;
        bit          busy_bad;
        ep = p; ev = v; res = 1'b1; wok = 1'b0; wr = 1'b0;
        exp_hit = 1'b1; exp_flt = 0;
        case (mode)
            0: ;                                                  // R6 read ignores permission
            1: begin wok = 1'b1; wr = 1'b1; end                   // R3 permitted write
            2: begin wr = 1'b1; exp_hit = 1'b0; exp_flt = 2; end  // R6 protection fault
            3: begin res = 1'b0; wok = 1'b1; exp_hit = 1'b0; exp_flt = 1; end // R5
            4: begin ep = p ^ 8'(1 << (n % 8)); exp_hit = 1'b0; exp_flt = 1; end // R4 pid
            5: begin ev = v ^ 6'(1 << (n % 6)); exp_hit = 1'b0; exp_flt = 1; end // R4 vpn
            default: begin res = 1'b0; wr = 1'b1; exp_hit = 1'b0; exp_flt = 1; end // R5 priority
        endcase
        h = slot_of(p, v);
        exp_pa = exp_hit ? {h, off} : 15'd0;
        @(negedge clk);
        cur_entry = {ep, ev, 1'(n), 1'(n >> 1), wok, res};
        tbl_base = base; req_pid = p; req_vpn = v; req_off = off; req_write = wr;
        req_valid = 1'b1;
        rd0 = rd_count;
        chk(req_ready == 1'b1, "R7 idle ready", int'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        cnt = 0; busy_bad = 1'b0;
        while (!rsp_valid && cnt < 50) begin
            if (req_ready) busy_bad = 1'b1;
            @(negedge clk);
            cnt++;
        end
        chk(!busy_bad, "R7 busy", int'(busy_bad), 0);
        chk(rsp_valid == 1'b1, "R3 response", int'(rsp_valid), 1);
        chk(m_addr == 16'(base + 16'(h)), "R2 address", int'(m_addr), int'(16'(base + 16'(h))));
        chk(rd_count - rd0 == 1, "R7 read count", rd_count - rd0, 1);
        chk(rsp_hit == exp_hit, exp_hit ? "R3 hit" : "R4 R5 R6 miss", int'(rsp_hit), int'(exp_hit));
        chk(int'(rsp_fault) == exp_flt, "R4 R5 R6 fault code", int'(rsp_fault), exp_flt);
        chk(rsp_paddr == exp_pa, "R3 paddr", int'(rsp_paddr), int'(exp_pa));
        if (hold) begin
            repeat (2) @(negedge clk);
            chk(rsp_valid && rsp_hit == exp_hit && int'(rsp_fault) == exp_flt
                && rsp_paddr == exp_pa, "R8 hold", int'(rsp_paddr), int'(exp_pa));
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R8 release", int'(rsp_valid), 0);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(mem_rd_en == 1'b0, "R1 rd_en", int'(mem_rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !rsp_valid && !mem_rd_en, "R1 after release", int'(req_ready), 1);
        n = 0;
        for (int p = 0; p < 256; p += 3) begin
            for (int v = 0; v < 64; v++) begin
                lat = n % 3;
                lookup(n % 7, 8'(p), 6'(v), 10'(n * 13), 16'(16'h0400 + n * 37),
                       (n % 5) == 0, n);
                n++;
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule